// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block picks one interrupt source out of a configurable set of sources. Every source has a pending flag, an enable flag and a 4-bit priority. A source whose pending and enable flags are both set becomes a candidate. A balanced tree of two-input comparators finds the highest priority among the candidates. When two candidates share a priority, the lower source number wins. The block registers the winner's number and its priority. It raises an interrupt request when the winning priority is strictly above both a global threshold and the threshold of the handler now running. It raises a wake-up indication when the winner sits at the top level.

A single order bit lets software count priorities downward. While the bit is set, every incoming priority and threshold is bit-inverted before evaluation, and the reported priority is inverted back. The comparison logic itself always works with 15 as the highest level. The state that holds priorities, enables and thresholds lives outside this block, and so do the input synchronisers.

Top module: `arb_prio_eval`

## Requirements
- R1: While rst_ni is low, and until the first clock edge after it rises, win_id_o, win_prio_o, irq_o and wake_o are all 0.
- R2: Source s (1..N_SRC) is a candidate only when pend_i[s-1] and en_i[s-1] are both 1. Its priority is prio_i[4*(s-1)+3 : 4*(s-1)]. A source that is not a candidate never appears on win_id_o.
- R3: win_id_o names the candidate with the highest effective priority. win_prio_o reports that priority.
- R4: When several candidates share the highest effective priority, win_id_o is the lowest source number among them.
- R5: When no candidate has an effective priority above 0, win_id_o is 0 and win_prio_o is the software encoding of level 0. That encoding is 0 in normal order and 15 in reverse order.
- R6: irq_o is 1 only when the effective winning priority is strictly greater than both the effective thr_global_i and the effective thr_cur_i. It is 0 when the winning priority is equal to or below either threshold.
- R7: wake_o is 1 exactly when the effective winning priority is 15.
- R8: When rev_order_i is 1, the effective value of each priority and threshold input is its bitwise inverse (15 minus the value), and win_prio_o reports the inverse of the effective winning priority. When rev_order_i is 0, effective values equal the inputs.
- R9: Outputs are evaluated from the inputs sampled at a clock edge and appear after that edge, one cycle of latency. They are re-evaluated every cycle, so clearing or disabling the winner changes the outputs on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_order_i | input | 1 | 1 selects reverse (downward-counting) priority encoding |
| pend_i | input | N_SRC | Pending flag per source; bit s-1 belongs to source s |
| en_i | input | N_SRC | Enable flag per source; bit s-1 belongs to source s |
| prio_i | input | 4*N_SRC | Packed 4-bit priority per source, source s in bits 4s-1:4s-4 |
| thr_global_i | input | 4 | Global priority threshold (software encoding) |
| thr_cur_i | input | 4 | Priority of the running handler (software encoding) |
| win_id_o | output | ID_W | Winning source number, 0 when nothing qualifies |
| win_prio_o | output | 4 | Winning priority in software encoding |
| irq_o | output | 1 | Interrupt request to the target |
| wake_o | output | 1 | Wake-up indication for a top-level winner |

## Verification
The hardest case to reach from the ports is a tie at the top of the tree between candidates in different subtrees, with the winner also sitting exactly on one threshold while the other threshold is lower. Random patterns rarely produce that. The stimulus therefore forces a single shared priority across all sources under sparse random pending and enable masks. It also drives directed sequences where a threshold equals the winning level, sits one below it, or lies on the other threshold. The same sweeps are then repeated with the order bit set, and sequences clear or disable the current winner cycle by cycle. Every cycle is compared against a behavioural scan model in the bench.

// File: rtl/arb_prio_pkg.sv
`timescale 1ns/1ps
package arb_prio_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_TOP  = '1;
  localparam prio_t PRIO_NONE = '0;

  // software <-> internal encoding; self-inverse
  function automatic prio_t order_map(input logic rev, input prio_t v);
    return rev ? ~v : v;
  endfunction
endpackage

// File: rtl/arb_prio_node.sv
`timescale 1ns/1ps
module arb_prio_node
  import arb_prio_pkg::*;
#(
  parameter int unsigned ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  prio_t           lo_prio_i,
  input  logic [ID_W-1:0] lo_id_i,
  input  prio_t           hi_prio_i,
  input  logic [ID_W-1:0] hi_id_i,
  output prio_t           prio_o,
  output logic [ID_W-1:0] id_o
);
  // lo side always carries the lower IDs, so it keeps ties
  logic take_hi;
  assign take_hi = hi_prio_i > lo_prio_i;
  assign prio_o  = take_hi ? hi_prio_i : lo_prio_i;
  assign id_o    = take_hi ? hi_id_i   : lo_id_i;

  assert_node_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_o >= lo_prio_i) && (prio_o >= hi_prio_i));
  assert_node_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((id_o == lo_id_i) && (prio_o == lo_prio_i)) || ((id_o == hi_id_i) && (prio_o == hi_prio_i)));
  assert_node_tie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_prio_i == hi_prio_i) |-> (id_o == lo_id_i));
endmodule

// File: rtl/arb_prio_gate.sv
`timescale 1ns/1ps
module arb_prio_gate
  import arb_prio_pkg::*;
#(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned LEAVES = 32
) (
  input  logic                  rev_i,
  input  logic [N_SRC-1:0]      pend_i,
  input  logic [N_SRC-1:0]      en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output prio_t                 leaf_prio_o [LEAVES],
  output logic [LEAVES-1:0]     live_o
);
  // leaf 0 is the reserved "no source" slot
  assign leaf_prio_o[0] = PRIO_NONE;
  assign live_o[0]      = 1'b0;

  for (genvar i = 1; i < LEAVES; i++) begin : g_leaf
    if (i <= N_SRC) begin : g_src
      logic cand;
      assign cand           = pend_i[i-1] & en_i[i-1];
      assign live_o[i]      = cand;
      assign leaf_prio_o[i] = cand ? order_map(rev_i, prio_i[(i-1)*PRIO_W +: PRIO_W]) : PRIO_NONE;
    end else begin : g_pad
      assign live_o[i]      = 1'b0;
      assign leaf_prio_o[i] = PRIO_NONE;
    end
  end
endmodule

// File: rtl/arb_prio_tree.sv
`timescale 1ns/1ps
module arb_prio_tree
  import arb_prio_pkg::*;
#(
  parameter int unsigned LEAVES = 32,
  parameter int unsigned ID_W   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  prio_t           leaf_prio_i [LEAVES],
  output prio_t           root_prio_o,
  output logic [ID_W-1:0] root_id_o
);
  localparam int unsigned NODES = 2*LEAVES - 1;
  localparam int unsigned INNER = LEAVES - 1;

  prio_t           nd_prio [NODES];
  logic [ID_W-1:0] nd_id   [NODES];

  // heap layout: node k has children 2k+1 (lower IDs) and 2k+2
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    assign nd_prio[INNER+i] = leaf_prio_i[i];
    assign nd_id[INNER+i]   = ID_W'(i);
  end

  for (genvar k = 0; k < INNER; k++) begin : g_node
    arb_prio_node #(.ID_W(ID_W)) u_node (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lo_prio_i (nd_prio[2*k+1]),
      .lo_id_i   (nd_id[2*k+1]),
      .hi_prio_i (nd_prio[2*k+2]),
      .hi_id_i   (nd_id[2*k+2]),
      .prio_o    (nd_prio[k]),
      .id_o      (nd_id[k])
    );
  end

  assign root_prio_o = nd_prio[0];
  assign root_id_o   = nd_id[0];

  assert_root_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (root_prio_o == PRIO_NONE) |-> (root_id_o == '0));
endmodule

// File: rtl/arb_prio_eval.sv
`timescale 1ns/1ps
module arb_prio_eval
  import arb_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 31,
  localparam int unsigned ID_W = $clog2(N_SRC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rev_order_i,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       thr_global_i,
  input  logic [PRIO_W-1:0]       thr_cur_i,
  output logic [ID_W-1:0]         win_id_o,
  output logic [PRIO_W-1:0]       win_prio_o,
  output logic                    irq_o,
  output logic                    wake_o
);
  localparam int unsigned LEAVES = 1 << ID_W;

  prio_t             leaf_prio [LEAVES];
  logic [LEAVES-1:0] live;
  prio_t             root_prio;
  logic [ID_W-1:0]   root_id;

  arb_prio_gate #(.N_SRC(N_SRC), .LEAVES(LEAVES)) u_gate (
    .rev_i       (rev_order_i),
    .pend_i      (pend_i),
    .en_i        (en_i),
    .prio_i      (prio_i),
    .leaf_prio_o (leaf_prio),
    .live_o      (live)
  );

  arb_prio_tree #(.LEAVES(LEAVES), .ID_W(ID_W)) u_tree (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .leaf_prio_i (leaf_prio),
    .root_prio_o (root_prio),
    .root_id_o   (root_id)
  );

  prio_t thr_g, thr_c, thr_max;
  logic  fire, top_lvl;
  assign thr_g   = order_map(rev_order_i, thr_global_i);
  assign thr_c   = order_map(rev_order_i, thr_cur_i);
  assign thr_max = (thr_g > thr_c) ? thr_g : thr_c;
  assign fire    = root_prio > thr_max;
  assign top_lvl = root_prio == PRIO_TOP;

  logic [LEAVES-1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_id_o   <= '0;
      win_prio_o <= '0;
      irq_o      <= 1'b0;
      wake_o     <= 1'b0;
      live_q     <= '0;
    end else begin
      win_id_o   <= root_id;
      win_prio_o <= order_map(rev_order_i, root_prio);
      irq_o      <= fire;
      wake_o     <= top_lvl;
      live_q     <= live;
    end
  end

  assert_winner_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_id_o != '0) |-> live_q[win_id_o]);
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_id_o == '0) |-> (!irq_o && !wake_o));
  assert_irq_has_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_id_o != '0));
  assert_wake_has_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (win_id_o != '0));
endmodule

// File: tb/sim_arb_prio_eval.sv
`timescale 1ns/1ps
module sim_arb_prio_eval;
  localparam int N    = 31;
  localparam int ID_W = $clog2(N + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rev = 1'b0;
  logic [N-1:0]    pend = '0;
  logic [N-1:0]    en = '0;
  logic [N*4-1:0]  prio = '0;
  logic [3:0]      thr_g = '0;
  logic [3:0]      thr_c = '0;
  logic [ID_W-1:0] win_id;
  logic [3:0]      win_prio;
  logic            irq, wake;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  arb_prio_eval #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rev_order_i(rev),
    .pend_i(pend), .en_i(en), .prio_i(prio),
    .thr_global_i(thr_g), .thr_cur_i(thr_c),
    .win_id_o(win_id), .win_prio_o(win_prio), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural scan over sources
  task automatic model(output int id, output int pw, output int ir, output int wk);
    int best = 0;
    int tg, tc;
    id = 0;
    for (int s = 1; s <= N; s++) begin
      if (pend[s-1] && en[s-1]) begin
        int p = int'(prio[(s-1)*4 +: 4]);
        if (rev) p = 15 - p;
        if (p > best) begin best = p; id = s; end
      end
    end
    tg = rev ? 15 - int'(thr_g) : int'(thr_g);
    tc = rev ? 15 - int'(thr_c) : int'(thr_c);
    ir = (best > tg && best > tc) ? 1 : 0;
    wk = (best == 15) ? 1 : 0;
    pw = rev ? 15 - best : best;
  endtask

  // inputs are set at a negedge; check after the next posedge
  task automatic tick(input string tag);
    int e_id, e_pw, e_ir, e_wk;
    model(e_id, e_pw, e_ir, e_wk);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "win_id", int'(win_id), e_id);
    chk("R3", "win_prio", int'(win_prio), e_pw);
    chk("R6", "irq", int'(irq), e_ir);
    chk("R7", "wake", int'(wake), e_wk);
  endtask

  task automatic rand_prio(input int lo, input int hi);
    for (int s = 0; s < N; s++) prio[s*4 +: 4] = 4'(lo + int'($urandom % (hi - lo + 1)));
  endtask

  task automatic set_prio(input int s, input int v);
    prio[(s-1)*4 +: 4] = 4'(v);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pend = '1; en = '1; rand_prio(1, 15);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "win_id", int'(win_id), 0);
      chk("R1", "win_prio", int'(win_prio), 0);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "wake", int'(wake), 0);
    end
    pend = '0; en = '0; prio = '0;
    rst_n = 1'b1;
    chk("R1", "win_id after release", int'(win_id), 0);

    // R2: random candidates, masking by pend and en
    for (int c = 0; c < 200; c++) begin
      pend = N'($urandom); en = N'($urandom); rand_prio(0, 15);
      thr_g = 4'($urandom); thr_c = 4'($urandom % 4);
      tick("R2");
    end
    // R2: pending but disabled, and enabled but not pending
    pend = '1; en = '0; rand_prio(1, 15); tick("R2");
    pend = '0; en = '1; tick("R2");
    pend = '0; en = '0; pend[4] = 1'b1; set_prio(5, 15); tick("R2");

    // R4: single shared level, sparse masks
    for (int c = 0; c < 150; c++) begin
      int v = 1 + int'($urandom % 15);
      rand_prio(v, v);
      pend = N'($urandom) & N'($urandom); en = N'($urandom) | N'($urandom);
      thr_g = 4'(v); thr_c = 4'(v - 1);
      tick("R4");
    end
    pend = '1; en = '1; rand_prio(9, 9); tick("R4");
    pend = '0; pend[N-1] = 1'b1; pend[N-2] = 1'b1; tick("R4");

    // R5: nothing qualifies
    thr_g = 0; thr_c = 0;
    pend = '1; en = '1; rand_prio(0, 0); tick("R5");
    pend = '0; rand_prio(1, 15); tick("R5");
    rev = 1'b1; pend = '1; rand_prio(15, 15); tick("R5");
    rev = 1'b0;

    // R6: threshold edges around a single winner at level 7
    pend = '0; en = '1; rand_prio(1, 1); pend[9] = 1'b1; set_prio(10, 7);
    thr_g = 7; thr_c = 0; tick("R6");
    thr_g = 6; thr_c = 7; tick("R6");
    thr_g = 6; thr_c = 6; tick("R6");
    thr_g = 0; thr_c = 8; tick("R6");
    for (int c = 0; c < 200; c++) begin
      pend = N'($urandom); en = N'($urandom); rand_prio(0, 15);
      thr_g = 4'($urandom); thr_c = 4'($urandom);
      tick("R6");
    end

    // R7: top level and one below
    thr_g = 0; thr_c = 0; pend = '0; en = '1;
    pend[N-1] = 1'b1; set_prio(N, 15); tick("R7");
    set_prio(N, 14); tick("R7");
    pend[0] = 1'b1; set_prio(1, 15); tick("R7");

    // R8: reverse order
    rev = 1'b1;
    pend = '0; en = '1; pend[2] = 1'b1; set_prio(3, 0); thr_g = 15; thr_c = 15; tick("R8");
    thr_g = 0; tick("R8");
    pend[20] = 1'b1; set_prio(21, 0); tick("R8");
    for (int c = 0; c < 250; c++) begin
      pend = N'($urandom); en = N'($urandom); rand_prio(0, 15);
      thr_g = 4'($urandom); thr_c = 4'(15 - int'($urandom % 4));
      tick("R8");
    end
    rev = 1'b0;

    // R9: clear or disable the winner, one cycle at a time
    thr_g = 2; thr_c = 3;
    pend = '0; en = '1; rand_prio(1, 1);
    set_prio(1, 5); set_prio(8, 9); set_prio(N, 12);
    pend[0] = 1'b1; pend[7] = 1'b1; pend[N-1] = 1'b1;
    tick("R9");
    pend[N-1] = 1'b0; tick("R9");
    en[7] = 1'b0; tick("R9");
    pend[0] = 1'b0; tick("R9");
    pend[7] = 1'b1; en[7] = 1'b1; tick("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule